// File: doc/BRIEF.md
# Synthesizer Latch Load Sequencer

This block programs a serially loaded frequency synthesizer. A one-cycle start pulse captures three 24-bit words: a reference-divider word, a control word and a feedback-divider word. The block replaces the two low bits of each word with that latch's select code. It then shifts the three words out over a three-wire serial link made of an active-low chip select, a serial clock and a data line. The reference word goes first, the control word second and the feedback word last.

The first load after reset must give the synthesizer time to settle after the control word is written. Only on that load does the block hold off for a parameterised settle time before it sends the feedback word. Later loads go straight through. After the last word, the block samples the synthesizer's lock-detect input. If that sample is low, it waits a parameterised retry time and samples once more. It then pulses done and presents the lock result, which stays unchanged until the next load.

Top module: `synth_loader`

## Requirements
- R1: While reset is high and in the first cycle after it, chip select is high and the serial clock, busy, done and locked are all low.
- R2: A load sends exactly three words in this fixed order: reference word with low bits 2'b01, control word with low bits 2'b00, feedback word with low bits 2'b10. Bits 23..2 of each word are passed through unchanged.
- R3: Bits are sent MSB first. The data line is stable while the serial clock is high, the receiver samples on the rising edge, and the serial clock is low whenever chip select is high.
- R4: Chip select falls once for each word, frames exactly 24 rising serial-clock edges, and returns high between words.
- R5: On the first load after any reset, at least SETTLE cycles pass from chip select rising after the control word to chip select falling for the feedback word.
- R6: On every later load, that gap is shorter than SETTLE cycles.
- R7: If lock detect is high at the first sample, done pulses with locked high and without the retry wait.
- R8: If the first sample is low and lock detect is high at the second sample, done comes at least RETRY cycles after the last word and locked is high.
- R9: If both samples are low, done pulses with locked low.
- R10: Busy rises the cycle after an accepted start and stays high until the cycle done pulses, when it falls. Done lasts one cycle. A start pulse seen while busy is high starts no further words, and locked changes only when done pulses.
- R11: The words are captured at start. Changing the word inputs during a load does not change the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a load |
| ref_word | input | WORD_W | Reference-divider word (low two bits ignored) |
| ctl_word | input | WORD_W | Control word (low two bits ignored) |
| fb_word | input | WORD_W | Feedback-divider word (low two bits ignored) |
| lock_in | input | 1 | Lock-detect level from the synthesizer (asynchronous) |
| spi_cs_n | output | 1 | Active-low chip select, low for one word |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data, MSB first |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse when a load completes |
| locked | output | 1 | Lock result of the last load |

## Verification
Word values use alternating, all-ones, walking and arbitrary bit patterns. These show whether the low bits are overwritten, whether bit order is reversed and whether a word is shifted or truncated. Lock detect is tried in three ways: high from the start, rising between the two samples, and never rising. Each of the three lock outcomes produces its own latency and result. Loads are issued right after reset, back to back, and again after a second reset, so the presence or absence of the settle gap is tied to the first-load condition. One load changes its word inputs and pulses start again mid-transfer, to show that the captured words are used and that the second start is ignored.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;

  localparam int TAG_W = 2;

  typedef enum logic [TAG_W-1:0] {
    LATCH_CTL = 2'd0,
    LATCH_REF = 2'd1,
    LATCH_FB  = 2'd2
  } latch_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_SETTLE,
    ST_LOCK_A,
    ST_RETRY,
    ST_LOCK_B
  } seq_state_e;

endpackage

// File: rtl/spi_word_tx.sv
module spi_word_tx #(
  parameter int WORD_W   = 24,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [WORD_W-1:0] data,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              fin
);
  localparam int HC_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  logic              active_q;
  logic [HC_W-1:0]   hcnt_q;
  logic [BIT_W-1:0]  bcnt_q;
  logic [WORD_W-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      hcnt_q   <= '0;
      bcnt_q   <= '0;
      shreg_q  <= '0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active_q) begin
        if (go) begin
          active_q <= 1'b1;
          cs_n     <= 1'b0;
          sclk     <= 1'b0;
          hcnt_q   <= '0;
          bcnt_q   <= '0;
          shreg_q  <= data;
        end
      end else if (hcnt_q == HC_LAST) begin
        hcnt_q <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (bcnt_q == BIT_LAST) begin
            active_q <= 1'b0;
            cs_n     <= 1'b1;
            fin      <= 1'b1;
          end else begin
            bcnt_q  <= bcnt_q + 1'b1;
            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
          end
        end
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assign mosi = shreg_q[WORD_W-1];

endmodule

// File: rtl/delay_timer.sv
module delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/synth_loader.sv
module synth_loader
  import synth_loader_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int HALF_CYC  = 4,
  parameter int CLK_HZ    = 100_000_000,
  parameter int SETTLE_US = 10_000,
  parameter int RETRY_US  = 100_000,
  parameter int SYNC_FF   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] ref_word,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [WORD_W-1:0] fb_word,
  input  logic              lock_in,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              busy,
  output logic              done,
  output logic              locked
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
  localparam int RETRY_CYC  = CYC_PER_US * RETRY_US;
  localparam int MAX_CYC    = (SETTLE_CYC > RETRY_CYC) ? SETTLE_CYC : RETRY_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  seq_state_e        state_q;
  logic [1:0]        idx_q;
  logic              first_q;
  logic [WORD_W-1:0] ref_q, ctl_q, fb_q;
  logic              go_q;
  logic              tmr_load_q;
  logic [CNT_W-1:0]  tmr_val_q;
  logic              tmr_exp;
  logic              tx_fin;
  logic [WORD_W-1:0] tx_data;
  logic [SYNC_FF-1:0] sync_q;
  logic              lock_s;

  // lock-detect synchronizer
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_FF-2:0], lock_in};
  end
  assign lock_s = sync_q[SYNC_FF-1];

  // word select with latch tag in the low bits
  always_comb begin
    unique case (idx_q)
      2'd0:    tx_data = {ref_q[WORD_W-1:TAG_W], LATCH_REF};
      2'd1:    tx_data = {ctl_q[WORD_W-1:TAG_W], LATCH_CTL};
      default: tx_data = {fb_q[WORD_W-1:TAG_W],  LATCH_FB};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      idx_q      <= 2'd0;
      first_q    <= 1'b1;
      ref_q      <= '0;
      ctl_q      <= '0;
      fb_q       <= '0;
      go_q       <= 1'b0;
      tmr_load_q <= 1'b0;
      tmr_val_q  <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      locked     <= 1'b0;
    end else begin
      go_q       <= 1'b0;
      tmr_load_q <= 1'b0;
      done       <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            ref_q   <= ref_word;
            ctl_q   <= ctl_word;
            fb_q    <= fb_word;
            idx_q   <= 2'd0;
            go_q    <= 1'b1;
            busy    <= 1'b1;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tx_fin) begin
            if (idx_q == 2'd0) begin
              idx_q <= 2'd1;
              go_q  <= 1'b1;
            end else if (idx_q == 2'd1) begin
              if (first_q) begin
                tmr_load_q <= 1'b1;
                tmr_val_q  <= CNT_W'(SETTLE_CYC);
                state_q    <= ST_SETTLE;
              end else begin
                idx_q <= 2'd2;
                go_q  <= 1'b1;
              end
            end else begin
              state_q <= ST_LOCK_A;
            end
          end
        end
        ST_SETTLE: begin
          if (tmr_exp) begin
            first_q <= 1'b0;
            idx_q   <= 2'd2;
            go_q    <= 1'b1;
            state_q <= ST_SEND;
          end
        end
        ST_LOCK_A: begin
          if (lock_s) begin
            locked  <= 1'b1;
            done    <= 1'b1;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            tmr_load_q <= 1'b1;
            tmr_val_q  <= CNT_W'(RETRY_CYC);
            state_q    <= ST_RETRY;
          end
        end
        ST_RETRY: begin
          if (tmr_exp) state_q <= ST_LOCK_B;
        end
        ST_LOCK_B: begin
          locked  <= lock_s;
          done    <= 1'b1;
          busy    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load_q),
    .load_val (tmr_val_q),
    .expired  (tmr_exp)
  );

  spi_word_tx #(.WORD_W(WORD_W), .HALF_CYC(HALF_CYC)) u_tx (
    .clk  (clk),
    .rst  (rst),
    .go   (go_q),
    .data (tx_data),
    .cs_n (spi_cs_n),
    .sclk (spi_sclk),
    .mosi (spi_mosi),
    .fin  (tx_fin)
  );

endmodule

// File: rtl/synth_loader_chk.sv
module synth_loader_chk (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic busy,
  input logic done,
  input logic locked
);
  AST_CLK_PARKED: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk); // R3

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && spi_sclk) |-> $stable(spi_mosi)); // R3

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R10

  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(locked)); // R10

endmodule

bind synth_loader synth_loader_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi),
  .busy     (busy),
  .done     (done),
  .locked   (locked)
);

// File: tb/tb_synth_loader.sv
module tb_synth_loader;
  localparam int W      = 24;
  localparam int SETTLE = 200;
  localparam int RETRY  = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic lock_in = 1'b0;
  logic [W-1:0] ref_w = '0, ctl_w = '0, fb_w = '0;
  logic cs_n, sclk, mosi, busy, done, locked;

  synth_loader #(
    .WORD_W(W), .HALF_CYC(2), .CLK_HZ(1_000_000),
    .SETTLE_US(SETTLE), .RETRY_US(RETRY), .SYNC_FF(2)
  ) dut (
    .clk(clk), .rst(rst), .start(start),
    .ref_word(ref_w), .ctl_word(ctl_w), .fb_word(fb_w),
    .lock_in(lock_in), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .busy(busy), .done(done), .locked(locked)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int mon_err = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural receiver model: rebuilds frames from the serial pins
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  logic [W-1:0] sh = '0;
  int nb = 0;
  logic [W-1:0] fq[$];
  int bq[$];
  int fall_t[$];
  int rise_t[$];

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !cs_n) begin sh = '0; nb = 0; fall_t.push_back(cyc); end
      if (!cs_n && !prev_sclk && sclk) begin sh = {sh[W-2:0], mosi}; nb++; end
      if (!prev_cs && cs_n) begin fq.push_back(sh); bq.push_back(nb); rise_t.push_back(cyc); end
      if (cs_n && sclk) mon_err++;        // R3 clock must idle low
      if (!busy && !cs_n) mon_err++;      // R4 no frame outside a load
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    fq.delete(); bq.delete(); fall_t.delete(); rise_t.delete();
  endtask

  // mode: 0 lock at once, 1 lock after retry, 2 never lock
  task automatic run_load(input logic [W-1:0] r, input logic [W-1:0] c,
                          input logic [W-1:0] f, input int mode,
                          input bit first, input bit disturb);
    int done_t = -1;
    int late = -1;
    clear_mon();
    lock_in = (mode == 0);
    repeat (4) @(negedge clk);
    ref_w = r; ctl_w = c; fb_w = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (disturb) begin
      repeat (30) @(negedge clk);
      ref_w = ~r; ctl_w = ~c; fb_w = ~f; start = 1'b1;   // R11 and R10 stimulus
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (mode == 1 && rise_t.size() == 3 && late < 0) late = 0;
      if (late >= 0) begin
        late++;
        if (late == 50) lock_in = 1'b1;
      end
      if (done) begin
        done_t = cyc;
        chk(busy == 1'b0, "R10", "busy low with done", busy, 0);
        break;
      end
    end
    chk(done_t >= 0, "R10", "done seen", done_t, 1);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", done, 0);
    chk(fq.size() == 3, "R2", "frame count", fq.size(), 3);
    if (fq.size() == 3) begin
      chk(fq[0] == {r[W-1:2], 2'b01}, "R2", "ref frame", fq[0], {r[W-1:2], 2'b01});
      chk(fq[1] == {c[W-1:2], 2'b00}, "R2", "ctl frame", fq[1], {c[W-1:2], 2'b00});
      chk(fq[2] == {f[W-1:2], 2'b10}, "R11", "fb frame", fq[2], {f[W-1:2], 2'b10});
      chk(bq[0] == W && bq[1] == W && bq[2] == W, "R4", "bits per frame", bq[2], W);
      if (first)
        chk(fall_t[2] - rise_t[1] >= SETTLE, "R5", "settle gap", fall_t[2] - rise_t[1], SETTLE);
      else
        chk(fall_t[2] - rise_t[1] < SETTLE, "R6", "no settle gap", fall_t[2] - rise_t[1], SETTLE);
      if (mode == 0) begin
        chk(done_t - rise_t[2] < RETRY, "R7", "fast done", done_t - rise_t[2], RETRY);
        chk(locked == 1'b1, "R7", "locked", locked, 1);
      end else if (mode == 1) begin
        chk(done_t - rise_t[2] >= RETRY, "R8", "retry wait", done_t - rise_t[2], RETRY);
        chk(locked == 1'b1, "R8", "locked", locked, 1);
      end else begin
        chk(locked == 1'b0, "R9", "not locked", locked, 0);
      end
    end
    repeat (60) @(negedge clk);
    chk(fq.size() == 3 && cs_n == 1'b1, "R10", "no extra frames", fq.size(), 3);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && busy == 0 && done == 0 && locked == 0,
        "R1", "outputs in reset", {cs_n, sclk, busy, done, locked}, 5'b10000);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && busy == 0 && done == 0 && locked == 0,
        "R1", "outputs after reset", {cs_n, sclk, busy, done, locked}, 5'b10000);
  endtask

  initial begin
    do_reset();
    run_load(24'hA5C3F3, 24'h5A5A5A, 24'hFFFFFF, 0, 1'b1, 1'b1);
    run_load(24'h800001, 24'h123456, 24'h000003, 1, 1'b0, 1'b0);
    run_load(24'h0F0F0E, 24'hFFFFFF, 24'hC0FFEE, 2, 1'b0, 1'b0);
    run_load(24'h000000, 24'h7E0101, 24'h2468AC, 0, 1'b0, 1'b0);
    do_reset();
    run_load(24'h13579B, 24'hFEDCBA, 24'h010204, 0, 1'b1, 1'b0);
    chk(mon_err == 0, "R3", "pin protocol errors", mon_err, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule